// File: doc/BRIEF.md
# Weighted Threshold Gate with Hysteresis

This block is a state-holding threshold gate for a two-value delay-insensitive logic style. Each input wire is either DATA (1) or NULL (0). Each input has a positive integer weight, and the gate adds up the weights of the DATA inputs. The output moves to DATA when that sum reaches the threshold. After that it stays at DATA while any input is still DATA, and it goes back to NULL only once all inputs are NULL. Between these two conditions the output keeps its last value. This hysteresis is what lets such gates mark the completeness of a data wavefront and of a null wavefront.

The gate is a clocked evaluation model with a synchronous reset. The output is registered, so the decision made on the inputs at one rising edge is visible from that edge on. The parameters are the threshold `THRESH`, the input count `N` (1 to 8) and a packed vector `WEIGHTS` holding one 4-bit weight per input. A weight greater than one behaves exactly like connecting that input several times. No input is inverted and no weight can be negative.

Top module: `thr_gate`

## Requirements
- R1: While `rst` is high at a rising edge, `y` becomes 0 (NULL) at that edge.
- R2: When `y` is 0 and the weighted sum of DATA inputs is at least `THRESH` at a rising edge, `y` is 1 after that edge.
- R3: When `y` is 0 and the weighted sum is below `THRESH`, `y` stays 0 after the edge.
- R4: When `y` is 1 and at least one input is 1, `y` stays 1 after the edge, even if the sum is below `THRESH`.
- R5: When `y` is 1 and every input is 0, `y` is 0 after the edge.
- R6: Input i contributes `WEIGHTS[4*i+3:4*i]` to the sum. The default configuration has N=4, THRESH=3 and weights {1,2,1,1} for inputs 0..3 (that is, 16'h1121), so input 1 counts twice.
- R7: Elaboration fails when THRESH is 0, when THRESH exceeds the sum of the weights, when N is outside 1..8, or when any weight is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | N | Input wires, 1 = DATA, 0 = NULL |
| y | output | 1 | Gate output, 1 = DATA, 0 = NULL |

## Verification
The only internal state is the output flag, so a wrong state shows at `y` one edge after the stimulus that caused it. Two kinds of fault are distinct. A wrong set decision shows up at the edge where the weighted sum first reaches or first exceeds the threshold. A wrong hold decision shows up only when a falling wavefront drops the sum below the threshold while some input is still DATA. The bench first sweeps every input pattern from both output states, which covers both kinds of fault. It then replays monotonic wavefronts, one input rising at a time and then one input falling at a time, so that the sum crosses the threshold in both directions.

// File: rtl/thr_gate.sv
module thr_gate #(
  parameter int N = 4,
  parameter int THRESH = 3,
  parameter logic [4*N-1:0] WEIGHTS = 16'h1121
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic         y
);
  localparam int WMAX = 15 * N;
  localparam int SW = $clog2(WMAX + 1);

  function automatic int wsum_all();
    int s = 0;
    for (int i = 0; i < N; i++) s += int'(WEIGHTS[4*i +: 4]);
    return s;
  endfunction

  function automatic bit any_zero_weight();
    for (int i = 0; i < N; i++) if (WEIGHTS[4*i +: 4] == 4'd0) return 1'b1;
    return 1'b0;
  endfunction

  // R7
  if (N < 1 || N > 8) begin : g_bad_n
    $error("thr_gate: N out of range");
  end
  if (THRESH < 1 || THRESH > wsum_all()) begin : g_bad_thresh
    $error("thr_gate: THRESH out of range");
  end
  if (any_zero_weight()) begin : g_bad_weight
    $error("thr_gate: zero weight");
  end

  logic [SW-1:0] part [N+1];
  assign part[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_acc
    assign part[i+1] = part[i] + (din[i] ? SW'(WEIGHTS[4*i +: 4]) : SW'(0));
  end

  wire [SW-1:0] total = part[N];
  wire reach = total >= SW'(THRESH);
  wire empty = ~|din;

  always_ff @(posedge clk) begin
    if (rst) y <= 1'b0;
    else if (!y && reach) y <= 1'b1;
    else if (y && empty) y <= 1'b0;
  end

  // R1
  reset_null_chk: assert property (@(posedge clk) rst |=> !y);
  // R3
  no_early_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!y && !reach) |=> !y);
  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (y && !empty) |=> y);
  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (y && empty) |=> !y);
  // R2
  set_chk: assert property (@(posedge clk) disable iff (rst)
    (!y && reach) |=> y);
endmodule

// File: tb/thr_gate_test.sv
module thr_gate_test;
  localparam int N = 4;
  localparam int TH = 3;
  localparam logic [15:0] W = 16'h1121;

  logic clk = 0, rst = 1;
  logic [N-1:0] din = '0;
  logic y;
  int checks = 0, errors = 0;
  bit model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thr_gate #(.N(N), .THRESH(TH), .WEIGHTS(W)) uut (.clk(clk), .rst(rst), .din(din), .y(y));

  function automatic int wsum(logic [N-1:0] v);
    int s = 0;
    for (int i = 0; i < N; i++) if (v[i]) s += int'(W[4*i +: 4]);
    return s;
  endfunction

  task automatic check(bit exp, string req);
    checks++;
    if (y !== exp) begin
      errors++;
      $display("FAIL %s din=%b actual=%b expected=%b", req, din, y, exp);
    end
  endtask

  function automatic string tag(bit prev, logic [N-1:0] v);
    if (!prev) return (wsum(v) >= TH) ? "R2/R6" : "R3/R6";
    return (v == 0) ? "R5" : "R4";
  endfunction

  task automatic step(logic [N-1:0] v);
    string t;
    t = tag(model, v);
    din = v;
    @(posedge clk);
    if (!model && wsum(v) >= TH) model = 1;
    else if (model && v == 0) model = 0;
    #2 check(model, t);
  endtask

  task automatic force_state(bit s);
    if (s) begin step('1); end
    else begin step('0); end
  endtask

  initial begin
    din = 4'b1111;
    @(posedge clk); @(posedge clk);
    #2 check(0, "R1");
    rst = 0;
    model = 0;
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 16; v++) begin
        force_state(s[0]);
        step(v[3:0]);
      end
    step(4'b0010); step(4'b0110); step(4'b0100); step(4'b0000);
    step(4'b0001); step(4'b0101); step(4'b1101); step(4'b1100); step(4'b1000); step(4'b0000);
    for (int r = 0; r < 40; r++) begin
      logic [N-1:0] cur = '0;
      int order [N];
      for (int i = 0; i < N; i++) order[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int t = order[i]; order[i] = order[j]; order[j] = t;
      end
      for (int i = 0; i < N; i++) begin cur[order[i]] = 1'b1; step(cur); end
      for (int i = N - 1; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int t = order[i]; order[i] = order[j]; order[j] = t;
      end
      for (int i = 0; i < N; i++) begin cur[order[i]] = 1'b0; step(cur); end
    end
    step(4'b1111);
    rst = 1; din = 4'b1111;
    @(posedge clk); #2 check(0, "R1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule